// File: doc/BRIEF.md
# Paged I/O Register Decoder

This block sits on the I/O side of a small 8-bit processor bus with a 16-bit address. The bus has its own I/O read and I/O write strobes, separate from memory cycles, so a memory access never reaches these registers. The upper address byte picks the I/O page: only the all-ones value selects it. That page hit is also exported as an active-low select, so other I/O logic can reuse the same decode.

Inside the page, the lower address byte picks a register. In full-decode mode each byte value names one slot. A parameterised number of 8-bit registers sits at the bottom slots. A bank of one-bit outputs sits at a parameterised base, and each bit has its own slot. In simple mode, each low address line acts as the select for one 8-bit register, and the bit bank cannot be reached. Registers are write-only unless a mask parameter marks them readable, and only readable registers feed the read path. The one-bit outputs let software set or clear a single line without a read-modify-write of a wider port.

Top module: `io_page_regs`

## Requirements
- R1: `page_sel_no` is 0 exactly when `addr_i[15:8]` is 8'hFF, whatever the strobes are.
- R2: State changes only on a rising clock edge where `io_wr_i` is 1 and the page is hit. An edge with `io_wr_i` low (a memory cycle) or with the page missed leaves `regs_o` and `bits_o` unchanged.
- R3: In full-decode mode (`SIMPLE_MODE`=0), an I/O write to slot k (`addr_i[7:0]`=k, k < `NUM_REGS`) loads `wdata_i` into register k only. Register k appears at `regs_o[8k+7:8k]`.
- R4: While `io_rd_i` is 1 and the page is hit, `rdata_o` gives the selected readable register combinationally. Otherwise `rdata_o` is 8'h00.
- R5: A read of a write-only slot, a one-bit slot, or an unimplemented slot returns 8'h00.
- R6: In full-decode mode, an I/O write to slot `BIT_BASE`+i loads `wdata_i[0]` into `bits_o[i]` and leaves every other bit unchanged. The default `BIT_BASE` is 8'h40.
- R7: In simple mode, an I/O write loads `wdata_i` into every register k whose address line `addr_i[k]` is 1.
- R8: In simple mode, a read returns the bitwise OR of all readable registers whose address line is 1.
- R9: An active-low reset `rst_ni` clears all registers and one-bit outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| rdata_o | output | 8 | Read data, 8'h00 when not reading |
| page_sel_no | output | 1 | I/O page select, active low |
| regs_o | output | NUM_REGS*8 | Register contents, register k in byte k |
| bits_o | output | NUM_BITS | One-bit output registers |

## Verification
Every register drives `regs_o` or `bits_o` directly. A corrupted register, or a write to the wrong slot, therefore shows at the ports on the edge after the faulty write. This holds even for write-only registers, whose readback stays 8'h00. A wrong read mask or wrong read selection shows on `rdata_o` in the same cycle as the read, because the read path has no register. A one-bit write that disturbs a neighbouring bit shows on `bits_o` one edge after the write.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int SLOT_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/io_page_decode.sv
module io_page_decode
  import io_dec_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int NUM_BITS    = 8,
  parameter int BIT_BASE    = 64,
  parameter bit SIMPLE_MODE = 1'b0
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                page_hit_o,
  output logic [NUM_REGS-1:0] byte_sel_o,
  output logic [NUM_BITS-1:0] bit_sel_o
);
  logic [SLOT_W-1:0] slot;

  assign slot       = addr_i[SLOT_W-1:0];
  // wide AND of the page byte, i.e. the inverse of a NAND page strobe
  assign page_hit_o = &addr_i[ADDR_W-1:SLOT_W];

  if (SIMPLE_MODE) begin : g_simple
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_line
      assign byte_sel_o[i] = slot[i];
    end
    assign bit_sel_o = '0;
  end else begin : g_full
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      assign byte_sel_o[i] = (slot == SLOT_W'(i));
    end
    for (genvar j = 0; j < NUM_BITS; j++) begin : g_bit
      assign bit_sel_o[j] = (slot == SLOT_W'(BIT_BASE + j));
    end

    always_comb begin
      if (!$isunknown(addr_i))
        assert_single_slot_R3: assert ($onehot0({byte_sel_o, bit_sel_o}))
          else $error("full decode selected more than one slot");
    end
  end
endmodule

// File: rtl/io_byte_regs.sv
module io_byte_regs
  import io_dec_pkg::*;
#(
  parameter int                NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] READ_MASK = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [NUM_REGS-1:0]        sel_i,
  input  byte_t                      wdata_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output byte_t                      rdata_o
);
  byte_t rd_part [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    byte_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q <= '0;
      else if (wr_en_i && sel_i[i]) q <= wdata_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = q;

    // only readable registers reach the read path
    if (READ_MASK[i]) begin : g_rd
      assign rd_part[i] = sel_i[i] ? q : '0;
    end else begin : g_wo
      assign rd_part[i] = '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i)
      for (int i = 0; i < NUM_REGS; i++) rdata_o |= rd_part[i];
  end

  assert_hold_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o))
    else $error("registers changed without a write");
endmodule

// File: rtl/io_bit_regs.sv
module io_bit_regs #(
  parameter int NUM_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_BITS-1:0] sel_i,
  input  logic                din_i,
  output logic [NUM_BITS-1:0] bits_o
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  bits_o[i] <= 1'b0;
      else if (wr_en_i && sel_i[i]) bits_o[i] <= din_i;
    end
  end

  assert_one_bit_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bits_o ^ $past(bits_o)) <= 1)
    else $error("more than one output bit changed in one cycle");
endmodule

// File: rtl/io_page_regs.sv
module io_page_regs
  import io_dec_pkg::*;
#(
  parameter int                  NUM_REGS    = 8,
  parameter int                  NUM_BITS    = 8,
  parameter int                  BIT_BASE    = 64,
  parameter bit                  SIMPLE_MODE = 1'b0,
  parameter logic [NUM_REGS-1:0] READ_MASK   = NUM_REGS'(5)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [15:0]                addr_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       io_rd_i,
  input  logic                       io_wr_i,
  output logic [7:0]                 rdata_o,
  output logic                       page_sel_no,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [NUM_BITS-1:0]        bits_o
);
  logic                page_hit;
  logic [NUM_REGS-1:0] byte_sel;
  logic [NUM_BITS-1:0] bit_sel;
  logic                wr_en, rd_en;

  assign wr_en       = io_wr_i & page_hit;
  assign rd_en       = io_rd_i & page_hit;
  assign page_sel_no = ~page_hit;

  io_page_decode #(
    .NUM_REGS(NUM_REGS), .NUM_BITS(NUM_BITS),
    .BIT_BASE(BIT_BASE), .SIMPLE_MODE(SIMPLE_MODE)
  ) u_dec (
    .addr_i(addr_i), .page_hit_o(page_hit),
    .byte_sel_o(byte_sel), .bit_sel_o(bit_sel)
  );

  io_byte_regs #(.NUM_REGS(NUM_REGS), .READ_MASK(READ_MASK)) u_bytes (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .sel_i(byte_sel), .wdata_i(wdata_i), .regs_o(regs_o), .rdata_o(rdata_o)
  );

  io_bit_regs #(.NUM_BITS(NUM_BITS)) u_bits (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .sel_i(bit_sel),
    .din_i(wdata_i[0]), .bits_o(bits_o)
  );

  assert_idle_read_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rd_i || page_sel_no) |-> (rdata_o == 8'h00))
    else $error("read data driven outside an I/O page read");

  assert_no_offpage_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_wr_i || page_sel_no) |=> ($stable(regs_o) && $stable(bits_o)))
    else $error("state changed without an I/O page write");
endmodule

// File: tb/io_page_regs_test.sv
module io_page_regs_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  rdata, rdata_s;
  logic        psel_n, psel_n_s;
  logic [63:0] regs, regs_s;
  logic [7:0]  bits, bits_s;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  io_page_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .io_rd_i(io_rd), .io_wr_i(io_wr), .rdata_o(rdata),
    .page_sel_no(psel_n), .regs_o(regs), .bits_o(bits));

  io_page_regs #(.SIMPLE_MODE(1'b1), .READ_MASK(8'h0F)) uut_s (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .io_rd_i(io_rd), .io_wr_i(io_wr), .rdata_o(rdata_s),
    .page_sel_no(psel_n_s), .regs_o(regs_s), .bits_o(bits_s));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read_chk(input string req, input logic [15:0] a,
                             input logic [7:0] exp, input bit simple);
    @(negedge clk);
    addr = a; io_rd = 1'b1;
    #1;
    check(req, simple ? rdata_s : rdata, exp);
    io_rd = 1'b0;
  endtask

  typedef struct packed {
    logic        is_wr;
    logic [15:0] a;
    logic [7:0]  d;   // write data, or expected read data
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b1, 16'hFF00, 8'hA5},  // R3 write slot 0
    '{1'b0, 16'hFF00, 8'hA5},  // R4 readback
    '{1'b1, 16'hFF02, 8'h3C},  // R3 write slot 2
    '{1'b0, 16'hFF02, 8'h3C},  // R4
    '{1'b0, 16'hFF00, 8'hA5},  // R3 slot 0 untouched
    '{1'b1, 16'hFF01, 8'h77},  // write-only slot 1
    '{1'b0, 16'hFF01, 8'h00},  // R5 write-only reads zero
    '{1'b0, 16'hFF20, 8'h00},  // R5 unimplemented
    '{1'b1, 16'hFE02, 8'h11},  // R2 off-page write
    '{1'b0, 16'hFF02, 8'h3C},  // R2 slot 2 kept
    '{1'b0, 16'hFF43, 8'h00}   // R5 bit slot reads zero
  };

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 regs reset", regs, 64'h0);
    check("R9 bits reset", bits, 64'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VT[i].is_wr) io_write(VT[i].a, VT[i].d);
      else io_read_chk("R3/R4/R5/R2 table", VT[i].a, VT[i].d, 1'b0);
    end

    check("R3 write-only slot held", regs[15:8], 8'h77);
    check("R3 unwritten slot 3", regs[31:24], 8'h00);

    // R1 page select
    @(negedge clk); addr = 16'hFF10; #1;
    check("R1 page hit", psel_n, 1'b0);
    addr = 16'h7F10; #1;
    check("R1 page miss", psel_n, 1'b1);
    addr = 16'hFFFF; io_rd = 1'b0; #1;
    check("R1 no strobe needed", psel_n, 1'b0);

    // R4 no strobe, no data
    addr = 16'hFF00; #1;
    check("R4 idle read", rdata, 8'h00);

    // R2 memory cycle: address on page, no I/O strobe
    @(negedge clk); addr = 16'hFF00; wdata = 8'h5E;
    @(negedge clk);
    check("R2 memory cycle", regs[7:0], 8'hA5);

    // R6 single-bit outputs
    io_write(16'hFF43, 8'h01);
    check("R6 set bit 3", bits, 8'h08);
    io_write(16'hFF45, 8'hFF);
    check("R6 set bit 5", bits, 8'h28);
    io_write(16'hFF43, 8'hFE);
    check("R6 clear bit 3 by data bit 0", bits, 8'h20);
    check("R6 bytes untouched", regs[23:0], 24'h3C77A5);

    // R9 reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R9 regs cleared", regs, 64'h0);
    check("R9 bits cleared", bits, 64'h0);
    rst_ni = 1'b1;

    // R7/R8 simple mode
    io_write(16'hFF05, 8'h5A);
    check("R7 lines 0 and 2 loaded", regs_s, 64'h0000_0000_005A_005A);
    io_write(16'hFF02, 8'h81);
    check("R7 line 1 only", regs_s, 64'h0000_0000_005A_815A);
    io_read_chk("R8 single line", 16'hFF01, 8'h5A, 1'b1);
    io_read_chk("R8 OR of lines 0,1", 16'hFF03, 8'hDB, 1'b1);
    io_write(16'hFF10, 8'hC3);
    io_read_chk("R8 write-only line 4", 16'hFF10, 8'h00, 1'b1);
    check("R7 line 4 loaded", regs_s[39:32], 8'hC3);
    check("R7 simple bits unreachable", bits_s, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule